// File: doc/BRIEF.md
# Byte-Wide SPI Master with Sticky Fault Flags

This peripheral drives an SPI bus as master, one byte at a time. Software reaches it through a small register port with two addresses: a control/status byte and a data byte. Writing the data byte while the master is enabled and idle launches an 8-bit full-duplex exchange. The byte clocked in from the slave is kept in a receive holding register until software reads it.

Five status bits report what happened: a read-only busy bit and four sticky event flags (transfer done, receive overrun, write collision, mode fault). Only software clears the sticky flags. Software may also set them itself to force an interrupt. The single interrupt output is the OR of the four sticky flags, gated by an interrupt-enable input. A chip-select input can be watched for a competing master. Its fault level is chosen by an input pin. A fault stops the exchange at once and drops the block out of master mode.

The serial clock idles low. Its period is 2×(N+1) system clocks, where N is the divider input. Data goes out MSB first. The master samples the slave's bit on the rising edge of the serial clock and changes its own output on the falling edge.

Top module: `spi_fault_master`

## Requirements
- R1: After reset the control byte (address 0) reads 0x00, the serial clock is low and the interrupt output is low.
- R2: A data-byte write (address 1) made while the enable bit (bit 0) and the master bit (bit 1) are both 1 and busy (bit 7) is 0 starts a transfer. Busy then reads 1 for exactly 16×(N+1)+1 clock cycles, counted from the cycle after the write.
- R3: Each transfer gives 8 serial clock pulses. Each pulse is high for N+1 clocks and low for N+1 clocks. The output bit changes only on falling edges and is sent MSB first. The input is sampled on rising edges, and the assembled byte is read at address 1.
- R4: The done flag (bit 6) is set at the end of each transfer. It stays set until software writes 0 to it.
- R5: When a transfer completes while the previous received byte is still unread (it is marked read by a read strobe at address 1), the overrun flag (bit 5) is set. The new byte is dropped and the older byte stays readable.
- R6: A data-byte write during a busy transfer sets the collision flag (bit 4). The write is discarded: the byte being shifted out is unchanged and no new transfer follows.
- R7: With fault detection enabled (bit 2) in active master mode, a chip-select level equal to the fault-level input (0 = low faults, 1 = high faults) sets the mode-fault flag (bit 3). It also clears busy and the master bit, stops the serial clock low, and works whether a transfer is running or not.
- R8: With fault detection disabled (bit 2 = 0), the chip-select input has no effect. No mode fault is flagged and a transfer completes normally.
- R9: The interrupt output equals the interrupt-enable input ANDed with the OR of bits 6, 5, 4 and 3. Software writing 1 to any of these bits raises the interrupt when it is enabled.
- R10: A data-byte write while enable or master is 0 starts nothing: busy stays 0 and the serial clock stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (at address 1 marks the received byte as read) |
| regAddr | input | 1 | 0 = control/status byte, 1 = data byte |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for the addressed register (combinational) |
| clkDiv | input | DIV_W | Divider value N; half serial period is N+1 clocks |
| faultLevel | input | 1 | Chip-select level that signals a mode fault |
| irqEn | input | 1 | Interrupt enable |
| csIn | input | 1 | Chip-select input watched for mode faults |
| miso | input | 1 | Serial data from slave |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to slave |
| irq | output | 1 | Interrupt request |

## Verification
Transfers are run with patterns that are asymmetric end to end (0xA5 out against 0x3C in, and others). A bit-order or sampling-edge mistake then shows up as a different byte on one side or the other. Busy-length is measured at two divider settings, N=0 and N=3, which separates a correct 2×(N+1) period from an off-by-one divider. Back-to-back unread transfers with different slave bytes show whether the older or the newer byte survives an overrun. A mid-transfer buffer write with 0xFF shows whether a collision corrupts the outgoing shift. The chip-select input is driven to each fault level with detection on and off, both idle and mid-transfer.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int BYTE_W = 8;

  // control byte layout
  localparam int BIT_EN    = 0;
  localparam int BIT_MSTR  = 1;
  localparam int BIT_FLTEN = 2;
  localparam int BIT_FAULT = 3;
  localparam int BIT_COLL  = 4;
  localparam int BIT_OVR   = 5;
  localparam int BIT_DONE  = 6;
  localparam int BIT_BUSY  = 7;

  typedef struct packed {
    logic startXfer;
    logic abortXfer;
  } spimStrobes_t;
endpackage

// File: rtl/spim_dp.sv
module spim_dp
  import spim_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  spimStrobes_t         strobes,
  input  logic [BYTE_W-1:0]    txByte,
  input  logic [DIV_W-1:0]     clkDiv,
  input  logic                 miso,
  output logic                 sclk,
  output logic                 mosi,
  output logic                 xferDone,
  output logic [BYTE_W-1:0]    rxByte
);
  localparam int HALVES = 2 * BYTE_W;
  localparam int HALF_W = $clog2(HALVES);
  localparam logic [HALF_W-1:0] LAST_HALF = HALF_W'(HALVES - 1);

  logic                running;
  logic                sclkQ;
  logic [DIV_W-1:0]    divCnt;
  logic [HALF_W-1:0]   halfCnt;
  logic [BYTE_W-1:0]   txShift;
  logic [BYTE_W-1:0]   rxShift;
  logic                doneQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      sclkQ   <= 1'b0;
      divCnt  <= '0;
      halfCnt <= '0;
      txShift <= '0;
      rxShift <= '0;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (strobes.abortXfer) begin
        running <= 1'b0;
        sclkQ   <= 1'b0;
        divCnt  <= '0;
      end else if (strobes.startXfer) begin
        running <= 1'b1;
        sclkQ   <= 1'b0;
        divCnt  <= '0;
        halfCnt <= '0;
        txShift <= txByte;
      end else if (running) begin
        if (divCnt == clkDiv) begin
          divCnt  <= '0;
          halfCnt <= halfCnt + 1'b1;
          sclkQ   <= ~sclkQ;
          if (!sclkQ) begin
            rxShift <= {rxShift[BYTE_W-2:0], miso};
          end else if (halfCnt == LAST_HALF) begin
            running <= 1'b0;
            doneQ   <= 1'b1;
          end else begin
            txShift <= {txShift[BYTE_W-2:0], 1'b0};
          end
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
    end
  end

  assign sclk     = sclkQ;
  assign mosi     = txShift[BYTE_W-1];
  assign xferDone = doneQ;
  assign rxByte   = rxShift;

  // R3: serial clock is parked low whenever no transfer runs
  p_sclk_idle_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> !sclkQ);

  // R3: output bit is never changed on a rising serial edge
  p_mosi_hold_rise_r3: assert property (@(posedge clk) disable iff (!rstN)
    (running && $rose(sclkQ)) |-> $stable(txShift[BYTE_W-1]));

  // R2: completion is a single-cycle event
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic                 regRdEn,
  input  logic                 regAddr,
  input  logic [BYTE_W-1:0]    regWrData,
  input  logic                 csIn,
  input  logic                 faultLevel,
  input  logic                 irqEn,
  input  logic                 xferDone,
  input  logic [BYTE_W-1:0]    rxByte,
  output spimStrobes_t         strobes,
  output logic [BYTE_W-1:0]    regRdData,
  output logic                 irq
);
  logic busyQ, doneQ, ovrQ, collQ, faultQ, fltEnQ, mstrQ, enQ;
  logic rxUnread;
  logic [BYTE_W-1:0] rxHold;

  logic ctrlWr, dataWr, dataRd;
  logic enNext, mstrNext, fltEnNext;
  logic faultNow, abortNow, startNow, collideNow, dropNew;

  always_comb begin
    ctrlWr     = regWrEn && !regAddr;
    dataWr     = regWrEn && regAddr;
    dataRd     = regRdEn && regAddr;
    enNext     = ctrlWr ? regWrData[BIT_EN]    : enQ;
    mstrNext   = ctrlWr ? regWrData[BIT_MSTR]  : mstrQ;
    fltEnNext  = ctrlWr ? regWrData[BIT_FLTEN] : fltEnQ;
    faultNow   = enQ && mstrQ && fltEnQ && (csIn == faultLevel);
    abortNow   = busyQ && (faultNow || !(enNext && mstrNext));
    startNow   = dataWr && !busyQ && enQ && mstrQ && !faultNow;
    collideNow = dataWr && busyQ;
    dropNew    = xferDone && rxUnread && !dataRd;
  end

  assign strobes.startXfer = startNow;
  assign strobes.abortXfer = abortNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ    <= 1'b0;
      doneQ    <= 1'b0;
      ovrQ     <= 1'b0;
      collQ    <= 1'b0;
      faultQ   <= 1'b0;
      fltEnQ   <= 1'b0;
      mstrQ    <= 1'b0;
      enQ      <= 1'b0;
      rxUnread <= 1'b0;
      rxHold   <= '0;
    end else begin
      if (startNow)                   busyQ <= 1'b1;
      else if (abortNow || xferDone)  busyQ <= 1'b0;

      doneQ  <= (ctrlWr ? regWrData[BIT_DONE]  : doneQ)  | xferDone;
      ovrQ   <= (ctrlWr ? regWrData[BIT_OVR]   : ovrQ)   | dropNew;
      collQ  <= (ctrlWr ? regWrData[BIT_COLL]  : collQ)  | collideNow;
      faultQ <= (ctrlWr ? regWrData[BIT_FAULT] : faultQ) | faultNow;
      fltEnQ <= fltEnNext;
      mstrQ  <= mstrNext && !faultNow;
      enQ    <= enNext;

      if (xferDone && !dropNew) begin
        rxHold   <= rxByte;
        rxUnread <= 1'b1;
      end else if (dataRd) begin
        rxUnread <= 1'b0;
      end
    end
  end

  assign regRdData = regAddr ? rxHold
                             : {busyQ, doneQ, ovrQ, collQ, faultQ, fltEnQ, mstrQ, enQ};
  assign irq = irqEn && (doneQ || ovrQ || collQ || faultQ);

  // R10: busy only in active master mode
  p_busy_master_r10: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |-> (enQ && mstrQ));

  // R6: collision flags and leaves the running transfer alone
  p_collide_keep_r6: assert property (@(posedge clk) disable iff (!rstN)
    (collideNow && !abortNow && !xferDone) |=> (collQ && busyQ));

  // R5: overrun keeps the older received byte
  p_overrun_keep_r5: assert property (@(posedge clk) disable iff (!rstN)
    dropNew |=> (ovrQ && $stable(rxHold)));

  // R7: a fault stops the transfer and leaves master mode
  p_fault_stop_r7: assert property (@(posedge clk) disable iff (!rstN)
    faultNow |=> (faultQ && !busyQ && !mstrQ));

  // R8: with detection off the fault flag moves only by software
  p_cs_ignored_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!fltEnQ && !ctrlWr) |=> $stable(faultQ));

  // R4: done flag is sticky without a control write
  p_done_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    (doneQ && !ctrlWr) |=> doneQ);
endmodule

// File: rtl/spi_fault_master.sv
module spi_fault_master
  import spim_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic                 regRdEn,
  input  logic                 regAddr,
  input  logic [BYTE_W-1:0]    regWrData,
  output logic [BYTE_W-1:0]    regRdData,
  input  logic [DIV_W-1:0]     clkDiv,
  input  logic                 faultLevel,
  input  logic                 irqEn,
  input  logic                 csIn,
  input  logic                 miso,
  output logic                 sclk,
  output logic                 mosi,
  output logic                 irq
);
  spimStrobes_t        strobes;
  logic                xferDone;
  logic [BYTE_W-1:0]   rxByte;

  spim_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regRdEn   (regRdEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .csIn      (csIn),
    .faultLevel(faultLevel),
    .irqEn     (irqEn),
    .xferDone  (xferDone),
    .rxByte    (rxByte),
    .strobes   (strobes),
    .regRdData (regRdData),
    .irq       (irq)
  );

  spim_dp #(.DIV_W(DIV_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .txByte   (regWrData),
    .clkDiv   (clkDiv),
    .miso     (miso),
    .sclk     (sclk),
    .mosi     (mosi),
    .xferDone (xferDone),
    .rxByte   (rxByte)
  );
endmodule

// File: tb/spi_fault_master_tb.sv
module spi_fault_master_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0, regRdEn = 1'b0, regAddr = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic [7:0] clkDiv = 8'd3;
  logic       faultLevel = 1'b0, irqEn = 1'b1, csIn = 1'b1, miso = 1'b0;
  logic       sclk, mosi, irq;
  int         checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  spi_fault_master dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic addr, input logic [7:0] data);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = addr; regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = 1'b0;
    #1;
  endtask

  task automatic busRead(input logic addr, input logic markRead, output logic [7:0] val);
    @(negedge clk);
    regAddr = addr; regRdEn = markRead;
    #1 val = regRdData;
    @(negedge clk);
    regRdEn = 1'b0; regAddr = 1'b0;
    #1;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 400 && regRdData[7]; i++) @(negedge clk);
    #1;
  endtask

  // slave model inside the task: shifts slv out, captures mosi
  task automatic runXfer(input logic [7:0] tx, input logic [7:0] slv,
                         input bit collide, output logic [7:0] seen);
    seen = '0;
    miso = slv[7];
    busWrite(1'b1, tx);
    for (int i = 0; i < 8; i++) begin
      @(posedge sclk);
      seen = {seen[6:0], mosi};
      @(negedge sclk);
      if (i < 7) miso = slv[6-i];
      if (collide && i == 2) begin
        busWrite(1'b1, 8'hFF);
        chk("R6 busy kept after collision", regRdData[7], 1'b1);
      end
    end
    waitIdle();
  endtask

  task automatic testReset();
    chk("R1 ctrl reset", regRdData, 8'h00);
    chk("R1 irq reset", irq, 1'b0);
    chk("R1 sclk reset", sclk, 1'b0);
  endtask

  task automatic testBasic();
    logic [7:0] seen, v;
    busWrite(1'b0, 8'h03);
    runXfer(8'hA5, 8'h3C, 1'b0, seen);
    chk("R3 mosi byte MSB first", seen, 8'hA5);
    busRead(1'b0, 1'b0, v);
    chk("R4 done set, busy clear", v, 8'h43);
    chk("R9 irq on done", irq, 1'b1);
    busRead(1'b1, 1'b1, v);
    chk("R3 received byte", v, 8'h3C);
    repeat (10) @(negedge clk);
    busRead(1'b0, 1'b0, v);
    chk("R4 done sticky", v[6], 1'b1);
    busWrite(1'b0, 8'h03);
    chk("R4 done cleared by write", regRdData[6], 1'b0);
    chk("R9 irq low after clear", irq, 1'b0);
  endtask

  task automatic measureBusy(input logic [7:0] n);
    int cnt;
    logic [7:0] v;
    clkDiv = n;
    busWrite(1'b1, 8'h5A);
    cnt = 0;
    while (regRdData[7] && cnt < 1000) begin
      cnt++;
      @(negedge clk); #1;
    end
    chk($sformatf("R2 busy length N=%0d", n), cnt, 16 * (n + 1) + 1);
    busRead(1'b1, 1'b1, v);
    busWrite(1'b0, 8'h03);
  endtask

  task automatic testTiming();
    int hi;
    logic [7:0] seen;
    measureBusy(8'd0);
    measureBusy(8'd3);
    clkDiv = 8'd2;
    busWrite(1'b1, 8'h00);
    @(posedge sclk);
    hi = 0;
    while (sclk) begin @(posedge clk); #1; hi++; end
    chk("R3 sclk high width N=2", hi, 3);
    waitIdle();
    clkDiv = 8'd3;
    busRead(1'b1, 1'b1, seen);
    busWrite(1'b0, 8'h03);
  endtask

  task automatic testOverrun();
    logic [7:0] seen, v;
    runXfer(8'h11, 8'h5A, 1'b0, seen);
    chk("R5 no overrun on first", regRdData[5], 1'b0);
    runXfer(8'h22, 8'hC3, 1'b0, seen);
    chk("R5 overrun flagged", regRdData[5], 1'b1);
    busRead(1'b1, 1'b1, v);
    chk("R5 older byte kept", v, 8'h5A);
    busWrite(1'b0, 8'h03);
  endtask

  task automatic testCollision();
    logic [7:0] seen, v;
    runXfer(8'h96, 8'h69, 1'b1, seen);
    chk("R6 active byte intact", seen, 8'h96);
    chk("R6 collision flag", regRdData[4], 1'b1);
    repeat (20) @(negedge clk);
    chk("R6 no extra transfer", regRdData[7], 1'b0);
    busRead(1'b1, 1'b1, v);
    chk("R6 received byte", v, 8'h69);
    busWrite(1'b0, 8'h03);
  endtask

  task automatic testDisabled(input logic [7:0] mode);
    int highs = 0;
    busWrite(1'b0, mode);
    busWrite(1'b1, 8'hC0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); #1;
      if (sclk) highs++;
    end
    chk("R10 no busy when inactive", regRdData[7], 1'b0);
    chk("R10 sclk quiet when inactive", highs, 0);
    busWrite(1'b0, 8'h03);
  endtask

  task automatic testFaultIgnored();
    logic [7:0] seen, v;
    faultLevel = 1'b0; csIn = 1'b0;
    busWrite(1'b0, 8'h03);
    runXfer(8'h0F, 8'hF0, 1'b0, seen);
    chk("R8 no fault with detection off", regRdData[3], 1'b0);
    chk("R8 transfer completed", regRdData[6], 1'b1);
    busRead(1'b1, 1'b1, v);
    chk("R8 received byte", v, 8'hF0);
    csIn = 1'b1;
    busWrite(1'b0, 8'h03);
  endtask

  task automatic testFaultMid();
    busWrite(1'b0, 8'h07);
    busWrite(1'b1, 8'hAA);
    repeat (10) @(negedge clk);
    csIn = 1'b0;
    @(negedge clk); #1;
    chk("R7 fault flag, busy and master clear", regRdData & 8'h8B, 8'h09);
    chk("R7 sclk low after abort", sclk, 1'b0);
    chk("R9 irq on fault", irq, 1'b1);
    csIn = 1'b1;
    busWrite(1'b0, 8'h03);
  endtask

  task automatic testFaultHighIdle();
    faultLevel = 1'b1; csIn = 1'b0;
    busWrite(1'b0, 8'h07);
    chk("R7 no fault at inactive level", regRdData[3], 1'b0);
    @(negedge clk);
    csIn = 1'b1;
    @(negedge clk); #1;
    chk("R7 high-level fault when idle", regRdData & 8'h0A, 8'h08);
    faultLevel = 1'b0;
    busWrite(1'b0, 8'h03);
  endtask

  task automatic testSoftSet();
    irqEn = 1'b0;
    busWrite(1'b0, 8'h23);
    chk("R9 irq gated off", irq, 1'b0);
    irqEn = 1'b1; #1;
    chk("R9 soft overrun raises irq", irq, 1'b1);
    busWrite(1'b0, 8'h13);
    chk("R9 soft collision raises irq", irq, 1'b1);
    busWrite(1'b0, 8'h0B);
    chk("R9 soft fault raises irq", irq, 1'b1);
    busWrite(1'b0, 8'h43);
    chk("R9 soft done raises irq", irq, 1'b1);
    busWrite(1'b0, 8'h03);
    chk("R9 irq low with no flags", irq, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    testReset();
    rstN = 1'b1;
    testBasic();
    testTiming();
    testOverrun();
    testCollision();
    testDisabled(8'h01);
    testDisabled(8'h02);
    testFaultIgnored();
    testFaultMid();
    testFaultHighIdle();
    testSoftSet();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule